// File: doc/BRIEF.md
# Proportional-Integral Loop Filter for a Digital Oscillator Control Loop

This block turns a stream of phase-error samples into an unsigned control code for a digitally controlled oscillator. Each error sample arrives as a signed-magnitude word with an input strobe. The block scales the magnitude twice by fixed powers of two. One scaled copy is the proportional term. The other is the integral term.

The integral term of each sample is held until the next strobed sample, and is then added to or subtracted from an integrator register. The new integrator value, combined with the current proportional term, becomes the registered output code. The sign bit of each term chooses between addition and subtraction. The oscillator cannot run below its free-running frequency, so neither the integrator nor the output may go negative. A subtraction that returns no carry-out clamps its result to zero. An addition that carries out of the word saturates its result to all ones.

Two named states sequence the filter. `ST_PRIME` is entered at reset: no integral term has been captured yet, and the integrator holds. The transition *first sample* moves the filter to `ST_TRACK`. There, every strobed sample applies the stored integral term. The transition *reset* returns the filter to `ST_PRIME` from either state.

Top module: `pi_loop_filter`

## Requirements
- R1: While reset is high, and at the first sample point after it, `out_valid` is 0, `out_code` equals `INIT_CODE` (default 512) and the integrator equals `INIT_CODE`.
- R2: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` is 1, and is 0 otherwise.
- R3: The input field has bit 9 as the sign (1 = negative) and bits 8:0 as the magnitude. With the default parameters, the proportional magnitude is the magnitude shifted left by 1 and saturated at 1023. The integral magnitude is the magnitude shifted right by 2.
- R4: On each strobed sample, the integrator becomes the old integrator plus or minus the integral term captured from the previous strobed sample. It subtracts when that sample's sign was 1. The first sample after reset (`ST_PRIME`) leaves the integrator unchanged.
- R5: The output code for a sample is the updated integrator plus or minus the proportional term of that same sample. It subtracts when the sample's sign is 1.
- R6: An integrator subtraction whose subtrahend exceeds the integrator (carry-out 0) sets the integrator to 0.
- R7: An addition that exceeds 1023, in either the integrator or the output sum, gives 1023.
- R8: An output subtraction whose proportional term exceeds the updated integrator gives an output code of 0.
- R9: In a cycle with `in_valid` low, the integrator and `out_code` keep their values.
- R10: A negative zero input (sign 1, magnitude 0) behaves exactly like a positive zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking a new error sample |
| in_data | input | 10 | Signed-magnitude error sample: bit 9 sign, bits 8:0 magnitude |
| out_valid | output | 1 | High for one cycle after each sample |
| out_code | output | 10 | Unsigned oscillator control code |

## Verification
The integrator clamp and the output clamp can occur in the same cycle. A long run of large negative samples first drives the integrator to zero. The next negative sample then makes the integrator subtraction lose its carry while the proportional subtraction also underflows. A run of large positive samples provokes the matching case at the top, where both additions saturate together. Each such cycle is judged by comparing the output code with an integer model in the bench that clamps each stage on its own, so a wrong clamp in either stage shows up as a wrong code.

// File: rtl/lf_pkg.sv
package lf_pkg;

    // Filter sequencing states.
    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,   // no integral term captured since reset
        ST_TRACK = 1'b1    // integral term of previous sample is held
    } lf_state_e;

endpackage

// File: rtl/lf_scaler.sv
// Power-of-two gain on an unsigned magnitude; left shifts saturate.
module lf_scaler #(
    parameter int W     = 10,
    parameter int SHIFT = 1,
    parameter bit LEFT  = 1'b1
) (
    input  logic [W-2:0] mag_i,
    output logic [W-1:0] scaled_o
);
    localparam int MW   = W - 1;
    localparam int WIDE = MW + SHIFT + 1;

    generate
        if (LEFT) begin : g_left
            logic [WIDE-1:0] wide;
            always_comb begin
                wide = WIDE'(mag_i) << SHIFT;
                if (|(wide >> W)) begin
                    scaled_o = '1;
                end else begin
                    scaled_o = wide[W-1:0];
                end
            end
        end else begin : g_right
            always_comb begin
                scaled_o = W'(mag_i >> SHIFT);
            end
        end
    endgenerate

endmodule

// File: rtl/lf_addsub.sv
// Unsigned adder/subtractor with carry-based clamping at both ends.
module lf_addsub #(
    parameter int W = 10
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] term_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o
);
    logic [W-1:0] operand;
    logic [W:0]   raw;
    logic         carry;

    always_comb begin
        operand = sub_i ? ~term_i : term_i;
        raw     = {1'b0, base_i} + {1'b0, operand} + (W+1)'(sub_i);
        carry   = raw[W];
        if (sub_i && !carry) begin
            res_o = '0;            // subtrahend larger than minuend
        end else if (!sub_i && carry) begin
            res_o = '1;            // sum beyond the word
        end else begin
            res_o = raw[W-1:0];
        end
    end

endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter #(
    parameter int          W         = 10,
    parameter int          P_SHIFT   = 1,
    parameter bit          P_LEFT    = 1'b1,
    parameter int          I_SHIFT   = 2,
    parameter bit          I_LEFT    = 1'b0,
    parameter logic [9:0]  INIT_CODE = 10'd512
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_code
);
    import lf_pkg::*;

    localparam int MW = W - 1;
    localparam logic [W-1:0] INIT_W = W'(INIT_CODE);

    lf_state_e    state_q, state_d;
    logic [W-1:0] integ_q, integ_d;
    logic [W-1:0] cprev_mag_q;
    logic         cprev_neg_q;
    logic [W-1:0] code_d;

    logic          smp_neg;
    logic [MW-1:0] smp_mag;
    logic [W-1:0]  p_mag, i_mag;
    logic [W-1:0]  integ_term;

    assign smp_neg = in_data[W-1];
    assign smp_mag = in_data[MW-1:0];

    lf_scaler #(.W(W), .SHIFT(P_SHIFT), .LEFT(P_LEFT)) p_scale_i (
        .mag_i(smp_mag), .scaled_o(p_mag)
    );
    lf_scaler #(.W(W), .SHIFT(I_SHIFT), .LEFT(I_LEFT)) i_scale_i (
        .mag_i(smp_mag), .scaled_o(i_mag)
    );

    // No stored integral term while priming.
    assign integ_term = (state_q == ST_TRACK) ? cprev_mag_q : '0;

    lf_addsub #(.W(W)) integ_add_i (
        .base_i(integ_q), .term_i(integ_term),
        .sub_i(cprev_neg_q && (state_q == ST_TRACK)), .res_o(integ_d)
    );
    lf_addsub #(.W(W)) out_add_i (
        .base_i(integ_d), .term_i(p_mag), .sub_i(smp_neg), .res_o(code_d)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (in_valid) state_d = ST_TRACK;   // first sample
            ST_TRACK: state_d = ST_TRACK;
            default:  state_d = ST_PRIME;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and output registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q     <= INIT_W;
            cprev_mag_q <= '0;
            cprev_neg_q <= 1'b0;
            out_code    <= INIT_W;
            out_valid   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                integ_q     <= integ_d;
                cprev_mag_q <= i_mag;
                cprev_neg_q <= smp_neg;
                out_code    <= code_d;
            end
        end
    end

endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
    parameter int          W         = 10,
    parameter logic [9:0]  INIT_CODE = 10'd512
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] out_code,
    input logic [W-1:0] integ,
    input logic [W-1:0] cprev_mag,
    input logic         cprev_neg,
    input logic         tracking
);
    localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (integ == W'(INIT_CODE) && !out_valid && out_code == W'(INIT_CODE)));

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_prime_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !tracking) |=> (integ == $past(integ)));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && tracking && cprev_neg && integ < cprev_mag) |=> (integ == '0));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && tracking && !cprev_neg &&
         ({1'b0, integ} + {1'b0, cprev_mag} > MAXV)) |=> (integ == '1));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_code) && $stable(integ)));

endmodule

bind pi_loop_filter lf_checker #(.W(W), .INIT_CODE(INIT_CODE)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .out_code(out_code), .integ(integ_q), .cprev_mag(cprev_mag_q),
    .cprev_neg(cprev_neg_q), .tracking(state_q == lf_pkg::ST_TRACK)
);

// File: tb/pi_loop_filter_tb.sv
`timescale 1ns/1ps
module pi_loop_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [9:0] in_data = '0;
    logic       out_valid;
    logic [9:0] out_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int m_integ, m_cmag, m_last;
    bit m_cneg, m_track;
    string tag;

    always #2.5 clk = ~clk;

    pi_loop_filter dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_code(out_code)
    );

    function automatic int clampv(int v);
        if (v < 0) return 0;
        if (v > 1023) return 1023;
        return v;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_integ = 512; m_cmag = 0; m_cneg = 0; m_track = 0; m_last = 512;
    endtask

    // Called at a falling edge; checks at the next falling edge.
    task automatic sample(logic [9:0] x);
        int mag, p, ic, e;
        bit neg;
        neg = x[9];
        mag = int'(x[8:0]);
        p   = (mag * 2 > 1023) ? 1023 : mag * 2;   // R3 proportional gain
        ic  = mag / 4;                              // R3 integral gain
        if (m_track) m_integ = clampv(m_cneg ? m_integ - m_cmag : m_integ + m_cmag); // R4 R6 R7
        e = clampv(neg ? m_integ - p : m_integ + p);  // R5 R7 R8
        m_cmag = ic; m_cneg = neg; m_track = 1; m_last = e;
        in_valid = 1'b1;
        in_data  = x;
        @(negedge clk);
        in_valid = 1'b0;
        check({"R2 ", tag}, int'(out_valid), 1);
        check({"R5 ", tag}, int'(out_code), e);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 idle", int'(out_valid), 0);
        check("R9 idle hold", int'(out_code), m_last);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1 valid", int'(out_valid), 0);
        check("R1 code", int'(out_code), 512);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();

        // R10: negative zero as first and second sample.
        tag = "R10 negzero";
        sample(10'h200);
        sample(10'h200);
        sample(10'h000);

        // R3 R4 R5: full sweep of input codes with idle gaps.
        tag = "R3 R4 sweep";
        for (int i = 0; i < 1024; i++) begin
            sample(10'(i));
            if (i % 7 == 3) idle();
        end

        // R6 R8: drive integrator to the floor, both clamps together.
        do_reset();
        tag = "R6 R8 floor";
        for (int i = 0; i < 24; i++) sample(10'h3FF);
        sample(10'h281);
        idle();
        sample(10'h3C0);

        // R7: drive to the ceiling, both saturations together.
        tag = "R7 ceiling";
        for (int i = 0; i < 30; i++) sample(10'h1FF);
        sample(10'h100);
        idle();

        // Mixed pattern, back-to-back and gapped.
        tag = "R4 R5 mixed";
        for (int i = 0; i < 400; i++) begin
            sample(10'((i * 37 + 11) % 1024));
            if (i % 5 == 0) idle();
        end

        // R1: reset in mid-run, then first sample primes.
        do_reset();
        tag = "R4 prime";
        sample(10'h3FF);
        sample(10'h010);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule